// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm Interrupt

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the system clock down to one update strobe per second, and the seconds counter moves only on that strobe. Software reaches the block through a small word-addressed register bus. Through it, software reads the time, sets an alarm value and requests a new time. A requested time is held as pending and is applied on the next one-second update, never on the bus write itself.

When an update makes the counter equal the alarm value while the alarm is armed, a sticky raw flag is set. A mask bit decides whether that flag shows in the status register and on the interrupt pin. Software acknowledges the alarm by reading a dedicated acknowledge register; that read clears the flag and does nothing else. A control bit selects whether the counter stops at all ones or rolls over to zero.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, alarm, load, control, status and raw status registers all read 0, the version register reads the VERSION_ID parameter, and `irq` is low.
- R2: Registers are selected by byte address with bits [1:0] equal to 0.
  - 0x00 count (read only).
  - 0x04 alarm value (read/write).
  - 0x08 load value (read/write).
  - 0x0C control (read/write; bit 0 arm, bit 1 mask, bit 2 run, bit 3 roll-over; bits 31:4 read 0).
  - 0x10 status (read only).
  - 0x14 raw status (read only).
  - 0x18 acknowledge (reads 0).
  - 0x1C version (read only).
  - Writes to read-only registers change nothing.
  - Read data is valid in the same cycle as the request. A write takes effect at the clock edge that samples it.
- R3: While run is 1, the count rises by exactly 1 every TICK_DIV clocks. The first rise comes at the TICK_DIV-th rising edge after the edge that sets run.
- R4: While run is 0, the count holds and the prescaler restarts. A pending load is not applied.
- R5: A write to the load register leaves the count unchanged. On the next update strobe, the count takes the written value in place of an increment.
- R6: On an update with the count at 0xFFFFFFFF and no load pending, the count stays at all ones when roll-over is 0, and becomes 0 when roll-over is 1.
- R7: Raw status bit 0 is set at the update edge whose new count equals the alarm value, but only while arm is 1. With arm at 0 it is not set.
- R8: Status bit 0 equals raw bit 0 AND NOT mask, and `irq` equals status bit 0.
- R9: A read of the acknowledge register clears raw bit 0 at that clock edge and leaves the count and every other register unchanged. A match in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Alarm interrupt, level, follows status bit 0 |

## Verification
Read data is due in the same cycle as the address, so the bench drives each access after a falling edge and samples one time unit later, before the rising edge that commits it. Count updates land on rising edges TICK_DIV apart, counted from the edge that set run. The bench numbers its own rising edges and predicts the count as a base value plus the number of whole strobe periods elapsed. A load appears exactly at the first strobe edge after its write edge. The raw flag and `irq` change at the very strobe edge that produces the match, and they fall at the edge of the acknowledge read. The bench therefore samples `irq` one edge before and at the predicted match edge, and right after the acknowledge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 5;

    // word slot decoded from bus_addr[4:2]
    typedef enum logic [2:0] {
        SLOT_COUNT = 3'd0,
        SLOT_ALARM = 3'd1,
        SLOT_LOAD  = 3'd2,
        SLOT_CTRL  = 3'd3,
        SLOT_STAT  = 3'd4,
        SLOT_RAW   = 3'd5,
        SLOT_ACK   = 3'd6,
        SLOT_VER   = 3'd7
    } slot_e;

    // control bits, msb first: roll-over(3), run(2), mask(1), arm(0)
    typedef struct packed {
        logic roll;
        logic run;
        logic mask;
        logic arm;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (!run) begin
            pre_d.phase = '0;
        end else if (pre_q.phase == LAST) begin
            pre_d.phase = '0;
        end else begin
            pre_d.phase = pre_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && (pre_q.phase == LAST);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          roll,
    input  logic          ld_wr,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] nxt_cnt,
    output logic [DW-1:0] load,
    output logic          pend
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] load;
        logic          pend;
    } sec_t;

    sec_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (tick) begin
            if (sec_q.pend) begin
                sec_d.cnt  = sec_q.load;
                sec_d.pend = 1'b0;
            end else if (&sec_q.cnt) begin
                sec_d.cnt = roll ? '0 : sec_q.cnt;
            end else begin
                sec_d.cnt = sec_q.cnt + DW'(1);
            end
        end
        // a fresh write always re-arms the pending transfer
        if (ld_wr) begin
            sec_d.load = ld_val;
            sec_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    assign cnt     = sec_q.cnt;
    assign nxt_cnt = sec_d.cnt;
    assign load    = sec_q.load;
    assign pend    = sec_q.pend;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] nxt_cnt,
    input  logic [DW-1:0] alarm,
    input  logic          arm,
    input  logic          mask,
    input  logic          ack,
    output logic          hit,
    output logic          raw,
    output logic          stat
);
    typedef struct packed {
        logic raw;
    } alm_t;

    alm_t alm_d, alm_q;

    always_comb begin
        alm_d = alm_q;
        hit   = upd && arm && (nxt_cnt == alarm);
        if (hit)      alm_d.raw = 1'b1;
        else if (ack) alm_d.raw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_q <= '0;
        else        alm_q <= alm_d;
    end

    assign raw  = alm_q.raw;
    assign stat = alm_q.raw & ~mask;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 32768,
    parameter logic [31:0] VERSION_ID = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] alarm;
        ctrl_t         ctrl;
    } regs_t;

    regs_t reg_d, reg_q;

    slot_e         slot;
    logic          aligned;
    logic          wr_en;
    logic          rd_en;
    logic          ld_wr;
    logic          ack;
    logic          tick;
    logic          hit;
    logic          raw;
    logic          stat;
    logic          pend;
    logic [DW-1:0] cnt;
    logic [DW-1:0] nxt_cnt;
    logic [DW-1:0] load_q;
    logic          c_arm;
    logic          c_mask;
    logic          c_run;
    logic          c_roll;

    // ---------------- decode ----------------
    always_comb begin
        slot    = slot_e'(bus_addr[AW-1:2]);
        aligned = (bus_addr[1:0] == 2'b00);
        wr_en   = bus_sel && bus_wr && aligned;
        rd_en   = bus_sel && !bus_wr && aligned;
        ld_wr   = wr_en && (slot == SLOT_LOAD);
        ack     = rd_en && (slot == SLOT_ACK);
    end

    // ---------------- writable registers ----------------
    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            unique case (slot)
                SLOT_ALARM: reg_d.alarm = bus_wdata;
                SLOT_CTRL:  reg_d.ctrl  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign c_arm  = reg_q.ctrl.arm;
    assign c_mask = reg_q.ctrl.mask;
    assign c_run  = reg_q.ctrl.run;
    assign c_roll = reg_q.ctrl.roll;

    // ---------------- datapath ----------------
    rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (c_run),
        .tick (tick)
    );

    rtc_seconds u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .roll   (c_roll),
        .ld_wr  (ld_wr),
        .ld_val (bus_wdata),
        .cnt    (cnt),
        .nxt_cnt(nxt_cnt),
        .load   (load_q),
        .pend   (pend)
    );

    rtc_alarm u_alm (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (tick),
        .nxt_cnt(nxt_cnt),
        .alarm  (reg_q.alarm),
        .arm    (c_arm),
        .mask   (c_mask),
        .ack    (ack),
        .hit    (hit),
        .raw    (raw),
        .stat   (stat)
    );

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (slot)
                SLOT_COUNT: bus_rdata = cnt;
                SLOT_ALARM: bus_rdata = reg_q.alarm;
                SLOT_LOAD:  bus_rdata = load_q;
                SLOT_CTRL:  bus_rdata = DW'(reg_q.ctrl);
                SLOT_STAT:  bus_rdata = DW'(stat);
                SLOT_RAW:   bus_rdata = DW'(raw);
                SLOT_ACK:   bus_rdata = '0;
                SLOT_VER:   bus_rdata = VERSION_ID;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = stat;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
    import rtc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] load_q,
    input logic          pend,
    input logic          c_run,
    input logic          c_roll,
    input logic          c_mask,
    input logic          ack,
    input logic          hit,
    input logic          raw,
    input logic          irq
);
    a_r3_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(tick));

    a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !c_run |=> $stable(cnt));

    a_r5_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend) |=> (cnt == $past(load_q)));

    a_r6_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend && !c_roll && (&cnt)) |=> (&cnt));

    a_r6_roll_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend && c_roll && (&cnt)) |=> (cnt == '0));

    a_r7_hit_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);

    a_r8_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask |-> !irq);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !raw);
endmodule

bind sec_rtc rtc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (cnt),
    .load_q(load_q),
    .pend  (pend),
    .c_run (c_run),
    .c_roll(c_roll),
    .c_mask(c_mask),
    .ack   (ack),
    .hit   (hit),
    .raw   (raw),
    .irq   (irq)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
    localparam int          CLK_PERIOD = 10;
    localparam int          D          = 5;
    localparam logic [31:0] VER        = 32'h0A0B_0C0D;

    localparam logic [4:0] A_CNT = 5'h00, A_ALM = 5'h04, A_LD  = 5'h08, A_CTL = 5'h0C;
    localparam logic [4:0] A_ST  = 5'h10, A_RAW = 5'h14, A_ACK = 5'h18, A_VER = 5'h1C;
    localparam logic [31:0] B_ARM = 32'h1, B_MASK = 32'h2, B_RUN = 32'h4, B_ROLL = 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int          n_chk = 0;
    int          n_fail = 0;
    int          edge_n = 0;
    int          en_e = 0;
    int          base_e = 0;
    logic [31:0] base_v = '0;
    logic [31:0] v;
    logic [31:0] m;
    bit          done = 1'b0;

    sec_rtc #(.TICK_DIV(D), .VERSION_ID(VER)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic to_edge(input int t);
        while (edge_n < t) idle(1);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] r;
        bus_read(a, r);
        chk(tag, r, exp);
    endtask

    // count expected from whole strobe periods since an aligned base edge
    function automatic logic [31:0] exp_cnt();
        return base_v + 32'((edge_n - base_e) / D);
    endfunction

    function automatic int next_tick(input int e);
        return en_e + D * ((e - en_e) / D + 1);
    endfunction

    function automatic int match_edge(input logic [31:0] mv);
        return base_e + int'(mv - base_v) * D;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rchk("R1 count", A_CNT, 32'd0);
        rchk("R1 alarm", A_ALM, 32'd0);
        rchk("R1 load", A_LD, 32'd0);
        rchk("R1 ctrl", A_CTL, 32'd0);
        rchk("R1 status", A_ST, 32'd0);
        rchk("R1 raw", A_RAW, 32'd0);
        rchk("R1 version", A_VER, VER);

        // R4 stopped counter does not move
        idle(3 * D);
        rchk("R4 count with run clear", A_CNT, 32'd0);

        // R3 enable and sweep every phase across several strobes
        bus_write(A_CTL, B_RUN);
        en_e = edge_n; base_e = edge_n; base_v = '0;
        for (int i = 0; i < 6 * D; i++) begin
            rchk("R3 count sweep", A_CNT, exp_cnt());
        end

        // R5 deferred load
        begin
            int e, t;
            bus_write(A_LD, 32'd100);
            e = edge_n;
            t = next_tick(e);
            rchk("R5 count unchanged after load write", A_CNT, exp_cnt());
            rchk("R2 load readback", A_LD, 32'd100);
            to_edge(t - 1);
            rchk("R5 count before strobe", A_CNT, exp_cnt());
            to_edge(t);
            rchk("R5 count takes load", A_CNT, 32'd100);
            base_v = 32'd100; base_e = t;
            to_edge(t + 2 * D);
            rchk("R5 counting resumes", A_CNT, exp_cnt());
        end

        // R6 hold at top, then roll over
        begin
            int t;
            bus_write(A_LD, 32'hFFFF_FFFE);
            t = next_tick(edge_n);
            to_edge(t);
            rchk("R6 loaded near top", A_CNT, 32'hFFFF_FFFE);
            to_edge(t + D);
            rchk("R6 reaches top", A_CNT, 32'hFFFF_FFFF);
            to_edge(t + 2 * D);
            rchk("R6 holds at top without roll", A_CNT, 32'hFFFF_FFFF);
            bus_write(A_CTL, B_RUN | B_ROLL);
            to_edge(t + 3 * D);
            rchk("R6 rolls to zero", A_CNT, 32'd0);
            base_v = 32'd0; base_e = t + 3 * D;
        end

        // R7 R8 R9 armed alarm, unmasked
        begin
            int h;
            m = exp_cnt() + 32'd3;
            bus_write(A_ALM, m);
            bus_write(A_CTL, B_RUN | B_ROLL | B_ARM);
            h = match_edge(m);
            rchk("R2 alarm readback", A_ALM, m);
            to_edge(h - 1);
            chk("R7 irq low before match", {31'd0, irq}, 32'd0);
            to_edge(h);
            chk("R7 irq at match edge", {31'd0, irq}, 32'd1);
            rchk("R8 status set", A_ST, 32'd1);
            rchk("R7 raw set", A_RAW, 32'd1);
            rchk("R9 ack reads zero", A_ACK, 32'd0);
            chk("R9 irq cleared by ack", {31'd0, irq}, 32'd0);
            rchk("R9 raw cleared", A_RAW, 32'd0);
            rchk("R9 count untouched by ack", A_CNT, exp_cnt());
            rchk("R9 ctrl untouched by ack", A_CTL, B_RUN | B_ROLL | B_ARM);
            rchk("R9 alarm untouched by ack", A_ALM, m);
            to_edge(h + 3 * D);
            chk("R7 no repeat after passing", {31'd0, irq}, 32'd0);
        end

        // R8 masked alarm
        begin
            int h;
            bus_write(A_CTL, B_RUN | B_ROLL | B_ARM | B_MASK);
            m = exp_cnt() + 32'd3;
            bus_write(A_ALM, m);
            h = match_edge(m);
            to_edge(h);
            chk("R8 irq low while masked", {31'd0, irq}, 32'd0);
            rchk("R8 raw set while masked", A_RAW, 32'd1);
            rchk("R8 status low while masked", A_ST, 32'd0);
            bus_write(A_CTL, B_RUN | B_ROLL | B_ARM);
            chk("R8 irq after unmask", {31'd0, irq}, 32'd1);
            rchk("R8 status after unmask", A_ST, 32'd1);
            rchk("R9 ack", A_ACK, 32'd0);
            chk("R9 irq low after ack", {31'd0, irq}, 32'd0);
        end

        // R7 disarmed: no flag
        begin
            int h;
            bus_write(A_CTL, B_RUN | B_ROLL);
            m = exp_cnt() + 32'd3;
            bus_write(A_ALM, m);
            h = match_edge(m);
            to_edge(h + 1);
            rchk("R7 raw stays clear when disarmed", A_RAW, 32'd0);
            chk("R7 irq stays low when disarmed", {31'd0, irq}, 32'd0);
        end

        // R2 read-only and control field widths
        bus_write(A_CNT, 32'h5555_5555);
        rchk("R2 count ignores write", A_CNT, exp_cnt());
        bus_write(A_VER, 32'd0);
        rchk("R2 version ignores write", A_VER, VER);
        bus_write(A_RAW, 32'd1);
        rchk("R2 raw ignores write", A_RAW, 32'd0);
        bus_write(A_ST, 32'd1);
        rchk("R2 status ignores write", A_ST, 32'd0);
        bus_write(A_CTL, 32'hFFFF_FFF0 | B_RUN | B_ROLL);
        rchk("R2 ctrl upper bits read zero", A_CTL, B_RUN | B_ROLL);

        // R4 stop: count freezes and pending load waits
        bus_write(A_CTL, 32'd0);
        bus_read(A_CNT, v);
        idle(3 * D);
        rchk("R4 count frozen", A_CNT, v);
        bus_write(A_LD, 32'd7);
        idle(3 * D);
        rchk("R4 load not applied while stopped", A_CNT, v);

        finish_up();
    end
endmodule